// File: doc/BRIEF.md
# Pressure Sensor Packet Fetch Master (SPI, receive only)

This block is a receive-only serial master that pulls one measurement packet from a digital pressure sensor over a three-wire link. The wires are an active-low select (`ssN`), a serial clock (`sclk`) and a data input (`miso`). A one-cycle request starts a read of 2, 3 or 4 bytes. The block lowers the select and waits out the select-to-clock setup time. It then clocks in the chosen number of bits, most significant bit first, waits the last-edge hold time, raises the select and keeps it high for the bus-free gap before it will start another read.

Once the select has risen, the received bits are decoded. The decoded fields are the 2-bit status, the 14-bit bridge (pressure) value and the temperature. A full read gives 11 temperature bits and a 3-byte read gives 8 bits. A one-cycle `done` strobe marks the update. A stale flag reflects the status of the latest packet. A sticky fault flag records any fault status until reset. All timing is given in nanoseconds and kilohertz as parameters and is turned into system-clock cycle counts inside the block.

Top module: `spi_fetch_top`

## Requirements
- R1: While `rstN` is low and after its release, `ssN`=1, `sclk`=1, `busy`=0 and `done`=0, and `status`, `pressure`, `temperature`, `stale` and `fault` are all 0.
- R2: A `req` sampled high while `busy` is low starts a read: `ssN` and `busy` go high-to-low/low-to-high on that clock edge. `reqMode` selects the length as follows: 00 gives 2 bytes, 01 gives 3 bytes, and 10 or 11 give 4 bytes.
- R3: After `ssN` falls, `sclk` holds high for SETUP = ceil(2500 ns x f_clk) cycles (125 at 50 MHz) before its first falling edge.
- R4: Each `sclk` low and high phase lasts HALF cycles, with HALF = max(ceil(f_clk/(2 x f_sclk)), ceil(600 ns x f_clk)), which is 32 at 50 MHz and 800 kHz. There are exactly 8 x bytes rising edges. `miso` is sampled at each rising edge, and the first bit sampled is the packet's most significant bit.
- R5: `ssN` rises HOLD = ceil(100 ns x f_clk) cycles (5) after the last rising `sclk` edge, with `sclk` left high. `done` is high for exactly the first cycle in which `ssN` is high again.
- R6: After `ssN` rises, `busy` stays high for GAP = ceil(2000 ns x f_clk) cycles (100), so `ssN` stays high at least that long. A `req` seen while `busy` is high is ignored. A `req` held high starts the next read on the first idle cycle.
- R7: In the `done` cycle, `status` holds the first two received bits and `pressure` holds the next 14 bits.
- R8: `temperature` is 0 for a 2-byte read. For a 3-byte read it is {byte 3, 3'b000}. For a 4-byte read it is {byte 3, bits 7..5 of byte 4}, and bits 4..0 of byte 4 have no effect.
- R9: `stale` is 1 exactly when the latest decoded status is 10.
- R10: A decoded status of 11 sets `fault`, which then stays 1 through later reads until reset.
- R11: `status`, `pressure`, `temperature` and `stale` change only in a `done` cycle and hold their values through the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a read when idle |
| reqMode | input | 2 | Read length select (00: 2 bytes, 01: 3 bytes, 1x: 4 bytes) |
| miso | input | 1 | Serial data from the sensor |
| ssN | output | 1 | Active-low sensor select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Read or bus-free gap in progress |
| done | output | 1 | One-cycle strobe when results update |
| status | output | 2 | Decoded status bits |
| pressure | output | 14 | Decoded bridge value |
| temperature | output | 11 | Decoded temperature (8-bit reads left-aligned) |
| stale | output | 1 | Latest status was 10 |
| fault | output | 1 | Sticky: a status of 11 was seen since reset |

## Verification
Properties are checked on every cycle:
- each clock phase is at least HALF cycles long;
- the clock moves only while the select is low, and only after SETUP cycles of select-low;
- the select rises only after HOLD cycles of clock-high;
- each select-high interval before a fall lasts at least GAP cycles;
- `done` coincides with the select rising;
- the fault flag is sticky;
- the decoded fields stay stable outside `done`.

The exact cycle counts, the bit count for each length code, MSB-first alignment, the temperature masking and scaling, the handling of requests during a read and back-to-back reads, and the clearing of the fault only by reset can be shown only by the bench scenarios. There, a behavioural sensor model and a per-cycle expected pin and field schedule are compared against the outputs.

// File: rtl/spi_fetch_pkg.sv
package spi_fetch_pkg;

  localparam int PKT_BITS   = 32;
  localparam int STATUS_W   = 2;
  localparam int PRESS_W    = 14;
  localparam int TEMP_W     = 11;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;   // clear the shift register
    logic       sample;  // take miso in at a rising sclk edge
    logic       finish;  // decode and publish results
    logic [1:0] lenSel;  // latched length code
  } fetchStrobe_t;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // number of bits read for a length code
  function automatic int bitsFor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2 * BYTE_W;
      2'b01:   return 3 * BYTE_W;
      default: return 4 * BYTE_W;
    endcase
  endfunction

endpackage

// File: rtl/spi_fetch_ctrl.sv
module spi_fetch_ctrl
  import spi_fetch_pkg::*;
#(
  parameter int SETUP_CYC = 125,
  parameter int HALF_CYC  = 32,
  parameter int HOLD_CYC  = 5,
  parameter int GAP_CYC   = 100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         req,
  input  logic [1:0]   reqMode,
  output logic         busy,
  output logic         ssN,
  output logic         sclk,
  output logic         done,
  output fetchStrobe_t strb
);

  localparam int TIMER_MAX = maxInt(maxInt(SETUP_CYC, HALF_CYC), maxInt(HOLD_CYC, GAP_CYC));
  localparam int TW        = $clog2(TIMER_MAX + 1);
  localparam int BW        = $clog2(PKT_BITS + 1);
  localparam int CW        = TW + 1;

  fetchState_e     state;
  logic [TW-1:0]   timer;
  logic [BW-1:0]   bitCnt;
  logic [1:0]      lenSel;
  logic            timerZero;
  logic            lastBit;

  assign timerZero = (timer == '0);
  assign lastBit   = (bitCnt == BW'(bitsFor(lenSel) - 1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb.start  = (state == ST_IDLE) && req;
    strb.sample = (state == ST_LOW) && timerZero;
    strb.finish = (state == ST_HOLD) && timerZero;
    strb.lenSel = lenSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
      lenSel <= 2'b00;
      ssN    <= 1'b1;
      sclk   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!timerZero) timer <= timer - 1'b1;
      case (state)
        ST_IDLE: begin
          if (req) begin
            state  <= ST_SETUP;
            ssN    <= 1'b0;
            lenSel <= reqMode;
            bitCnt <= '0;
            timer  <= TW'(SETUP_CYC - 1);
          end
        end
        ST_SETUP: begin
          if (timerZero) begin
            sclk  <= 1'b0;
            timer <= TW'(HALF_CYC - 1);
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (timerZero) begin
            sclk   <= 1'b1;
            bitCnt <= bitCnt + 1'b1;
            if (lastBit) begin
              timer <= TW'(HOLD_CYC - 1);
              state <= ST_HOLD;
            end else begin
              timer <= TW'(HALF_CYC - 1);
              state <= ST_HIGH;
            end
          end
        end
        ST_HIGH: begin
          if (timerZero) begin
            sclk  <= 1'b0;
            timer <= TW'(HALF_CYC - 1);
            state <= ST_LOW;
          end
        end
        ST_HOLD: begin
          if (timerZero) begin
            ssN   <= 1'b1;
            done  <= 1'b1;
            timer <= TW'(GAP_CYC - 1);
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (timerZero) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- pin timing checkers ----------------
  logic          sclkQ;
  logic          ssQ;
  logic [CW-1:0] phaseCnt;    // cycles the previous sclk level was shown
  logic [CW-1:0] ssLowCnt;    // cycles ssN has been low
  logic [CW-1:0] ssHighCnt;   // cycles ssN has been high
  logic [CW-1:0] sinceRise;   // cycles since the last rising sclk edge

  function automatic logic [CW-1:0] satInc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ     <= 1'b1;
      ssQ       <= 1'b1;
      phaseCnt  <= '1;
      ssLowCnt  <= '0;
      ssHighCnt <= '1;
      sinceRise <= '1;
    end else begin
      sclkQ     <= sclk;
      ssQ       <= ssN;
      phaseCnt  <= (sclk != sclkQ) ? CW'(1) : satInc(phaseCnt);
      ssLowCnt  <= ssN ? '0 : satInc(ssLowCnt);
      ssHighCnt <= ssN ? satInc(ssHighCnt) : '0;
      sinceRise <= (sclk && !sclkQ) ? CW'(1) : satInc(sinceRise);
    end
  end

  // R3
  ss_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != sclkQ) |-> (ssLowCnt >= CW'(SETUP_CYC)));

  // R4
  sclk_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != sclkQ) |-> (phaseCnt >= CW'(HALF_CYC)));

  // R4
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sclk |-> !ssN);

  // R5
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && !ssQ) |-> (sinceRise >= CW'(HOLD_CYC)));

  // R5
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ssN && !ssQ));

  // R6
  bus_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ssN && ssQ) |-> (ssHighCnt >= CW'(GAP_CYC)));

  // R6
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssN && sclk));

endmodule

// File: rtl/spi_fetch_datapath.sv
module spi_fetch_datapath
  import spi_fetch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                miso,
  input  fetchStrobe_t        strb,
  output logic [STATUS_W-1:0] status,
  output logic [PRESS_W-1:0]  pressure,
  output logic [TEMP_W-1:0]   temperature,
  output logic                stale,
  output logic                fault
);

  localparam int TEMP_HI = PKT_BITS - STATUS_W - PRESS_W;   // first bit after the bridge word
  localparam int PAD3    = TEMP_W - BYTE_W;                 // zero fill for 8-bit reads

  logic [PKT_BITS-1:0] shiftReg;
  logic [PKT_BITS-1:0] aligned;
  logic [TEMP_W-1:0]   tempNext;
  logic [STATUS_W-1:0] statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.start) begin
      shiftReg <= '0;
    end else if (strb.sample) begin
      shiftReg <= {shiftReg[PKT_BITS-2:0], miso};
    end
  end

  // left-align the received bits so the first one sits at the top
  always_comb begin
    case (strb.lenSel)
      2'b00:   aligned = {shiftReg[2*BYTE_W-1:0], {(2*BYTE_W){1'b0}}};
      2'b01:   aligned = {shiftReg[3*BYTE_W-1:0], {BYTE_W{1'b0}}};
      default: aligned = shiftReg;
    endcase
  end

  always_comb begin
    case (strb.lenSel)
      2'b00:   tempNext = '0;
      2'b01:   tempNext = {aligned[TEMP_HI-1 -: BYTE_W], {PAD3{1'b0}}};
      default: tempNext = aligned[TEMP_HI-1 -: TEMP_W];
    endcase
  end

  assign statusNext = aligned[PKT_BITS-1 -: STATUS_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status      <= '0;
      pressure    <= '0;
      temperature <= '0;
      stale       <= 1'b0;
      fault       <= 1'b0;
    end else if (strb.finish) begin
      status      <= statusNext;
      pressure    <= aligned[PKT_BITS-STATUS_W-1 -: PRESS_W];
      temperature <= tempNext;
      stale       <= (statusNext == 2'b10);
      fault       <= fault | (statusNext == 2'b11);
    end
  end

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable({status, pressure, temperature, stale}));

endmodule

// File: rtl/spi_fetch_top.sv
module spi_fetch_top
  import spi_fetch_pkg::*;
#(
  parameter int CLK_KHZ      = 50000,
  parameter int SCLK_KHZ     = 800,
  parameter int SETUP_NS     = 2500,
  parameter int HOLD_NS      = 100,
  parameter int GAP_NS       = 2000,
  parameter int MIN_PHASE_NS = 600
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                req,
  input  logic [1:0]          reqMode,
  input  logic                miso,
  output logic                ssN,
  output logic                sclk,
  output logic                busy,
  output logic                done,
  output logic [STATUS_W-1:0] status,
  output logic [PRESS_W-1:0]  pressure,
  output logic [TEMP_W-1:0]   temperature,
  output logic                stale,
  output logic                fault
);

  localparam int NS_PER_KHZ = 1_000_000;
  localparam int HALF_CYC   = maxInt(1, maxInt(ceilDiv(CLK_KHZ, 2 * SCLK_KHZ),
                                               ceilDiv(MIN_PHASE_NS * CLK_KHZ, NS_PER_KHZ)));
  localparam int SETUP_CYC  = maxInt(1, ceilDiv(SETUP_NS * CLK_KHZ, NS_PER_KHZ));
  localparam int HOLD_CYC   = maxInt(1, ceilDiv(HOLD_NS * CLK_KHZ, NS_PER_KHZ));
  localparam int GAP_CYC    = maxInt(1, ceilDiv(GAP_NS * CLK_KHZ, NS_PER_KHZ));

  fetchStrobe_t strb;

  spi_fetch_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .HALF_CYC  (HALF_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .GAP_CYC   (GAP_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .reqMode (reqMode),
    .busy    (busy),
    .ssN     (ssN),
    .sclk    (sclk),
    .done    (done),
    .strb    (strb)
  );

  spi_fetch_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .miso        (miso),
    .strb        (strb),
    .status      (status),
    .pressure    (pressure),
    .temperature (temperature),
    .stale       (stale),
    .fault       (fault)
  );

endmodule

// File: tb/test_spi_fetch_top.sv
module test_spi_fetch_top;

  localparam int CLK_PERIOD_NS = 20;
  localparam int CLK_KHZ   = 1_000_000 / CLK_PERIOD_NS;
  localparam int HALF_A    = (CLK_KHZ + 2 * 800 - 1) / (2 * 800);
  localparam int HALF_B    = (600 * CLK_KHZ + 999_999) / 1_000_000;
  localparam int HALF      = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam int SETUP     = (2500 * CLK_KHZ + 999_999) / 1_000_000;
  localparam int HOLD      = (100 * CLK_KHZ + 999_999) / 1_000_000;
  localparam int GAP       = (2000 * CLK_KHZ + 999_999) / 1_000_000;
  localparam int WATCHDOG  = 190_000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  reqMode = 2'b00;
  logic        miso = 1'b1;
  logic        ssN, sclk, busy, done, stale, fault;
  logic [1:0]  status;
  logic [13:0] pressure;
  logic [10:0] temperature;

  spi_fetch_top i_spi_fetch_top (
    .clk(clk), .rstN(rstN), .req(req), .reqMode(reqMode), .miso(miso),
    .ssN(ssN), .sclk(sclk), .busy(busy), .done(done), .status(status),
    .pressure(pressure), .temperature(temperature), .stale(stale), .fault(fault)
  );

  initial forever #(CLK_PERIOD_NS / 2) clk = ~clk;

  // ---------------- sensor model ----------------
  logic [31:0] pkt = 32'h0;
  int          bitIdx = 0;

  always @(negedge ssN or negedge sclk) begin
    if (sclk) begin
      bitIdx = 0;                       // select just fell
    end else if (!ssN) begin
      if (bitIdx < 32) miso = pkt[5'(31 - bitIdx)];
      bitIdx++;
    end
  end

  // ---------------- reference schedule ----------------
  typedef struct packed {
    logic ss;
    logic sc;
    logic bz;
    logic dn;
    logic upd;
  } pinExp_t;

  localparam pinExp_t IDLE_EXP = '{ss: 1'b1, sc: 1'b1, bz: 1'b0, dn: 1'b0, upd: 1'b0};

  pinExp_t     pq[$];
  string       tq[$];
  pinExp_t     cur = IDLE_EXP;
  string       curTag = "R1";
  logic [1:0]  pendSt, expSt = '0;
  logic [13:0] pendPr, expPr = '0;
  logic [10:0] pendTp, expTp = '0;
  logic        expStale = 1'b0, expFault = 1'b0;
  int          checks = 0, errors = 0, cycles = 0;

  task automatic pushCyc(input logic ss, input logic sc, input logic dn, input string tag);
    pinExp_t e;
    e.ss = ss; e.sc = sc; e.bz = 1'b1; e.dn = dn; e.upd = dn;
    pq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic buildRead(input logic [1:0] mode);
    int nBits;
    nBits = (mode == 2'b00) ? 16 : (mode == 2'b01) ? 24 : 32;
    for (int i = 0; i < SETUP; i++) pushCyc(1'b0, 1'b1, 1'b0, (i == 0) ? "R2" : "R3");
    for (int b = 0; b < nBits; b++) begin
      for (int i = 0; i < HALF; i++) pushCyc(1'b0, 1'b0, 1'b0, "R4");
      if (b < nBits - 1)
        for (int i = 0; i < HALF; i++) pushCyc(1'b0, 1'b1, 1'b0, "R4");
    end
    for (int i = 0; i < HOLD; i++) pushCyc(1'b0, 1'b1, 1'b0, "R5");
    for (int i = 0; i < GAP; i++) pushCyc(1'b1, 1'b1, (i == 0), (i == 0) ? "R5" : "R6");
    pendSt = pkt[31:30];
    pendPr = pkt[29:16];
    case (mode)
      2'b00:   pendTp = 11'h0;
      2'b01:   pendTp = {pkt[15:8], 3'b000};
      default: pendTp = pkt[15:5];
    endcase
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL R6 watchdog: actual %0d cycles, expected completion below %0d", cycles, WATCHDOG);
      finishRun();
    end
    if (!rstN) begin
      pq.delete();
      tq.delete();
      cur = IDLE_EXP;
      curTag = "R1";
      expSt = '0; expPr = '0; expTp = '0; expStale = 1'b0; expFault = 1'b0;
    end else begin
      if (!cur.bz && req) buildRead(reqMode);
      if (pq.size() > 0) begin
        cur = pq.pop_front();
        curTag = tq.pop_front();
        if (cur.upd) begin
          expSt = pendSt;
          expPr = pendPr;
          expTp = pendTp;
          expStale = (pendSt == 2'b10);
          expFault = expFault | (pendSt == 2'b11);
        end
      end else begin
        cur = IDLE_EXP;
        curTag = "R2";
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    string dt;
    checks++;
    if ({ssN, sclk, busy, done} !== {cur.ss, cur.sc, cur.bz, cur.dn}) begin
      errors++;
      $display("FAIL %s pins {ssN,sclk,busy,done}: actual %b expected %b at cycle %0d",
               curTag, {ssN, sclk, busy, done}, {cur.ss, cur.sc, cur.bz, cur.dn}, cycles);
    end
    // R11: fields must hold while a read is under way
    dt = !rstN ? "R1" : (cur.bz && !cur.dn) ? "R11" : "R7";
    checks++;
    if ({status, pressure} !== {expSt, expPr}) begin
      errors++;
      $display("FAIL %s status/pressure: actual %b/%h expected %b/%h", dt, status, pressure, expSt, expPr);
    end
    dt = !rstN ? "R1" : (cur.bz && !cur.dn) ? "R11" : "R8";
    checks++;
    if (temperature !== expTp) begin
      errors++;
      $display("FAIL %s temperature: actual %h expected %h", dt, temperature, expTp);
    end
    dt = !rstN ? "R1" : (cur.bz && !cur.dn) ? "R11" : "R9";
    checks++;
    if (stale !== expStale) begin
      errors++;
      $display("FAIL %s stale: actual %b expected %b", dt, stale, expStale);
    end
    dt = !rstN ? "R1" : "R10";
    checks++;
    if (fault !== expFault) begin
      errors++;
      $display("FAIL %s fault: actual %b expected %b", dt, fault, expFault);
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] p, input logic [1:0] m);
    @(negedge clk); #1;
    pkt = p; reqMode = m; req = 1'b1;
    @(negedge clk); #1;
    req = 1'b0;
    waitIdle();
  endtask

  initial begin
    repeat (5) @(negedge clk);          // R1 reset values compared each cycle
    #1 rstN = 1'b1;
    repeat (4) @(negedge clk);

    fetch(32'h2ABC_D5E7, 2'b00);        // R7 pressure only, temperature 0 (R8)
    fetch(32'h5123_4567, 2'b01);        // reserved status, 8-bit temperature (R8)
    fetch(32'h9FED_CBA9, 2'b10);        // stale status (R9), full temperature
    fetch(32'h0F0F_F0FF, 2'b11);        // R8 low 5 bits of byte 4 masked

    // R6: requests during a read are ignored
    @(negedge clk); #1;
    pkt = 32'h3C5A_A5C3; reqMode = 2'b01; req = 1'b1;
    @(negedge clk); #1 req = 1'b0;
    repeat (400) @(negedge clk);
    #1 reqMode = 2'b00; req = 1'b1;
    repeat (20) @(negedge clk);
    #1 req = 1'b0;
    waitIdle();

    // R6: held request starts the next read right after the gap
    @(negedge clk); #1;
    pkt = 32'h6A5F_0E1D; reqMode = 2'b01; req = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    while (busy) @(negedge clk);
    while (!busy) @(negedge clk);
    #1 req = 1'b0;
    waitIdle();

    fetch(32'hC000_0000, 2'b10);        // R10 fault status
    fetch(32'h1234_5678, 2'b10);        // fault stays set, stale clears

    // R10: only reset clears the fault
    @(negedge clk); #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    fetch(32'h8765_4321, 2'b01);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule